// File: doc/BRIEF.md
# Lockable Control Register Bank

A bank of five 32-bit control registers on a simple synchronous bus. Every register can be written and read by software through the bus port. Each register can also be loaded through its own hardware write strobe and is always visible on a hardware output. Software access to four of the registers can be withheld at run time.

There are two sources for a lock. The key source is the bank's own key register: it locks its dependents whenever any bit of it is set. The pin source is an external active-low input, which passes through a synchronizer before it takes effect. Each lockable register blocks software reads, software writes, or both. A blocked or invalid access never changes state. It returns zero data and pulses an error flag.

Top module: `lockreg_bank`

## Requirements
- R1: After reset all five registers, `sw_rdata`, `sw_err` and `hw_q` are zero, and the pin synchronizer holds the unlocked level.
- R2: Word-aligned byte offsets select the registers. 0x00 is the read-guarded register, 0x04 the key, 0x08 the write-guarded register, 0x0C the fully guarded register and 0x10 the pin-guarded register. `hw_q` holds register k in bits [32k+31:32k].
- R3: While the key is nonzero, a software read of 0x00 is blocked. Software writes to 0x00 still take effect.
- R4: While the key is nonzero, a software write to 0x08 is blocked. Software reads of 0x08 still return its value.
- R5: While the key is nonzero, both software reads and software writes of 0x0C are blocked.
- R6: While the synchronized `lock_n_in` is low, both software reads and software writes of 0x10 are blocked. A change on `lock_n_in` takes effect after SYNC_STAGES clock edges.
- R7: The key at 0x04 is never blocked. Any nonzero value in it engages the key lock.
- R8: A blocked software write leaves its register unchanged. A blocked software read returns zero. Either one raises `sw_err` for exactly the following cycle.
- R9: Hardware writes ignore every lock. When a hardware write and an accepted software write hit the same register in the same cycle, the software data is stored.
- R10: A read or write at an offset that is unaligned, or at an offset of 0x14 or above, returns zero, raises `sw_err` and changes no register.
- R11: `sw_rdata` and `sw_err` are registered and respond one cycle after the request. `sw_rdata` is zero in any cycle that does not follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_n_in | input | 1 | External lock, active low, asynchronous to nothing but resynchronized |
| sw_addr | input | AW (8) | Byte address of the software access |
| sw_wr | input | 1 | Software write request |
| sw_wdata | input | DW (32) | Software write data |
| sw_rd | input | 1 | Software read request |
| sw_rdata | output | DW (32) | Read data, one cycle after the request |
| sw_err | output | 1 | Error pulse for a blocked or invalid access |
| hw_we | input | 5 | Per-register hardware write strobes |
| hw_wdata | input | 5*DW (160) | Per-register hardware write data |
| hw_q | output | 5*DW (160) | Current value of every register |

## Verification
The bench builds the bank with its default parameters: 32-bit data, an 8-bit address and a two-stage synchronizer. The 8-bit address lets the bench reach offsets past the mapped range as well as the top of the address space. With two synchronizer stages, the bench can pulse `lock_n_in` and see the pin lock engage and release exactly two edges later. A behavioural model runs beside the design and is compared on every clock. This covers key changes that take effect on the very next access, and collisions between hardware and software writes.

// File: rtl/lockreg_bank.sv
module lockreg_bank #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_n_in,
  input  logic [AW-1:0]      sw_addr,
  input  logic               sw_wr,
  input  logic [DW-1:0]      sw_wdata,
  input  logic               sw_rd,
  output logic [DW-1:0]      sw_rdata,
  output logic               sw_err,
  input  logic [4:0]         hw_we,
  input  logic [5*DW-1:0]    hw_wdata,
  output logic [5*DW-1:0]    hw_q
);
  localparam int NREG = 5;
  localparam int IW = AW - 2;

  logic [NREG-1:0][DW-1:0] regs;
  logic [SYNC_STAGES-1:0]  pin_sync;
  logic [SYNC_STAGES:0]    pin_chain;

  assign pin_chain = {pin_sync, lock_n_in};

  always_ff @(posedge clk) begin
    if (!rst_n) pin_sync <= '1;
    else        pin_sync <= pin_chain[SYNC_STAGES-1:0];
  end

  logic [IW-1:0] word_idx;
  logic [2:0]    ri;
  logic          mapped, key_locked, pin_locked;
  logic [NREG-1:0] rd_guard, wr_guard;
  logic          rd_ok, wr_ok, rd_bad, wr_bad;

  assign word_idx   = sw_addr[AW-1:2];
  assign ri         = word_idx[2:0];
  assign mapped     = (sw_addr[1:0] == 2'b00) && (word_idx < IW'(NREG));
  assign key_locked = |regs[1];
  assign pin_locked = !pin_sync[SYNC_STAGES-1];

  // bit k guards register k
  assign rd_guard = {pin_locked, key_locked, 1'b0, 1'b0, key_locked};
  assign wr_guard = {pin_locked, key_locked, key_locked, 1'b0, 1'b0};

  assign rd_ok  = sw_rd && mapped && !rd_guard[ri];
  assign wr_ok  = sw_wr && mapped && !wr_guard[ri];
  assign rd_bad = sw_rd && !rd_ok;
  assign wr_bad = sw_wr && !wr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_ok && ri == 3'(i))
          regs[i] <= sw_wdata;
        else if (hw_we[i])
          regs[i] <= hw_wdata[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_rdata <= '0;
      sw_err   <= 1'b0;
    end else begin
      sw_rdata <= rd_ok ? regs[ri] : '0;
      sw_err   <= rd_bad || wr_bad;
    end
  end

  assign hw_q = regs;

  p_readlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && sw_addr == AW'(0) && regs[1] != '0) |=> (sw_err && sw_rdata == '0));

  p_locker_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr == AW'(4)) |=> (hw_q[2*DW-1:DW] == $past(sw_wdata)));

  p_blocked_wr_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr == AW'(8) && regs[1] != '0 && !hw_we[2]) |=> $stable(hw_q[3*DW-1:2*DW]));

  p_err_on_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_rd || sw_wr) && (sw_addr[1:0] != 2'b00 || sw_addr >= AW'(20))) |=> sw_err);

  p_rdzero_noread_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rd |=> (sw_rdata == '0));
endmodule

// File: tb/test_lockreg_bank.sv
`timescale 1ns/1ps
module test_lockreg_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_n_in = 1'b1;
  logic [7:0] sw_addr = '0;
  logic sw_wr = 1'b0, sw_rd = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic sw_err;
  logic [4:0] hw_we = '0;
  logic [159:0] hw_wdata = '0;
  logic [159:0] hw_q;

  always #5 clk = ~clk;

  lockreg_bank i_lockreg_bank (
    .clk(clk), .rst_n(rst_n), .lock_n_in(lock_n_in),
    .sw_addr(sw_addr), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rd(sw_rd),
    .sw_rdata(sw_rdata), .sw_err(sw_err),
    .hw_we(hw_we), .hw_wdata(hw_wdata), .hw_q(hw_q)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] m [5];
  logic [1:0] msync = 2'b11;
  logic [31:0] exp_rdata = '0;
  logic exp_err = 1'b0;

  task automatic chk(string tag, string what, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [159:0] mflat();
    return {m[4], m[3], m[2], m[1], m[0]};
  endfunction

  task automatic compare(string tag);
    chk(tag, "rdata", 160'(sw_rdata), 160'(exp_rdata));
    chk(tag, "err", 160'(sw_err), 160'(exp_err));
    chk(tag, "hw_q", hw_q, mflat());
  endtask

  task automatic cyc(string tag, logic rd, logic wr, logic [7:0] a, logic [31:0] d,
                     logic [4:0] hwe = 5'b0, logic [159:0] hwd = '0);
    logic key, pin, mapped, rl, wl, rok, wok;
    int idx;
    sw_rd = rd; sw_wr = wr; sw_addr = a; sw_wdata = d; hw_we = hwe; hw_wdata = hwd;
    @(posedge clk);
    key = (m[1] != 0);
    pin = (msync[1] == 1'b0);
    idx = int'(a) / 4;
    mapped = (a % 4 == 0) && (a < 8'h14);
    rl = 1'b0; wl = 1'b0;
    if (mapped) begin
      if (idx == 0 || idx == 3) rl = key;
      if (idx == 2 || idx == 3) wl = key;
      if (idx == 4) begin rl = pin; wl = pin; end
    end
    rok = rd && mapped && !rl;
    wok = wr && mapped && !wl;
    exp_rdata = rok ? m[idx] : 32'h0;
    exp_err = (rd && !rok) || (wr && !wok);
    for (int k = 0; k < 5; k++) if (hwe[k]) m[k] = hwd[k*32 +: 32];
    if (wok) m[idx] = d;
    msync = {msync[0], lock_n_in};
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [159:0] hw_one(int k, logic [31:0] v);
    logic [159:0] r = '0;
    r[k*32 +: 32] = v;
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 5; k++) m[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) cyc("R1", 1, 0, 8'(k*4), 0);

    for (int k = 0; k < 5; k++) if (k != 1) cyc("R2", 0, 1, 8'(k*4), 32'hA0000000 + k);
    for (int k = 0; k < 5; k++) cyc("R2", 1, 0, 8'(k*4), 0);
    cyc("R9", 0, 0, 0, 0, 5'b00101, hw_one(0, 32'h1111) | hw_one(2, 32'h2222));

    cyc("R7", 0, 1, 8'h04, 32'h0000_0100);
    cyc("R3", 1, 0, 8'h00, 0);
    cyc("R3", 0, 1, 8'h00, 32'h3333);
    cyc("R4", 1, 0, 8'h08, 0);
    cyc("R4", 0, 1, 8'h08, 32'hDEAD);
    cyc("R8", 1, 0, 8'h08, 0);
    cyc("R5", 1, 0, 8'h0C, 0);
    cyc("R5", 0, 1, 8'h0C, 32'hBEEF);
    cyc("R5", 1, 1, 8'h0C, 32'hBEEF);
    cyc("R7", 1, 0, 8'h04, 0);
    cyc("R9", 0, 0, 0, 0, 5'b01100, hw_one(2, 32'h5A5A) | hw_one(3, 32'hA5A5));
    cyc("R9", 1, 0, 8'h08, 0);
    cyc("R9", 0, 1, 8'h04, 32'h8000_0000, 5'b00010, hw_one(1, 32'h7777));
    cyc("R7", 0, 1, 8'h00, 32'h4444);
    cyc("R9", 0, 1, 8'h08, 32'h9999, 5'b00100, hw_one(2, 32'h6666));
    cyc("R7", 0, 1, 8'h04, 32'h0);
    cyc("R3", 1, 0, 8'h00, 0);
    cyc("R5", 0, 1, 8'h0C, 32'hC0DE);
    cyc("R5", 1, 0, 8'h0C, 0);

    lock_n_in = 1'b0;
    cyc("R6", 1, 0, 8'h10, 0);
    cyc("R6", 1, 0, 8'h10, 0);
    cyc("R6", 1, 0, 8'h10, 0);
    cyc("R6", 0, 1, 8'h10, 32'hF00D);
    cyc("R6", 1, 0, 8'h10, 0);
    cyc("R6", 1, 0, 8'h08, 0);
    lock_n_in = 1'b1;
    cyc("R6", 0, 1, 8'h10, 32'h1234);
    cyc("R6", 0, 1, 8'h10, 32'h5678);
    cyc("R6", 1, 0, 8'h10, 0);

    cyc("R10", 1, 0, 8'h14, 0);
    cyc("R10", 0, 1, 8'h14, 32'hFFFF);
    cyc("R10", 1, 0, 8'hFC, 0);
    cyc("R10", 0, 1, 8'h05, 32'hEEEE);
    cyc("R10", 1, 0, 8'h06, 0);
    cyc("R10", 0, 1, 8'h0F, 32'h1);
    for (int k = 0; k < 5; k++) cyc("R10", 1, 0, 8'(k*4), 0);

    cyc("R11", 0, 0, 8'h00, 0);
    cyc("R11", 0, 1, 8'h00, 32'h77);
    cyc("R11", 1, 1, 8'h00, 32'h88);
    cyc("R11", 1, 0, 8'h00, 0);
    cyc("R11", 0, 0, 8'h00, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule